// File: doc/BRIEF.md
# Banked Register File Address Unit

This block is the data-side address path of a small 8-bit controller core. The data space holds 512 bytes, split into four banks of 128 locations each. An instruction supplies only a 7-bit file offset. The unit turns that offset into a 9-bit physical location in one of two ways. Normally the two bank-select bits of the status byte sit above the offset. When the offset is zero, the access goes instead through an 8-bit pointer register, and a ninth bit from the status byte completes the address. The unit holds the status byte and the pointer register itself, and a backing array supplies every other location.

Three offsets act the same in every bank. Offset 00h is the indirect window, offset 03h is the status byte and offset 04h is the pointer. This holds whether such a location is reached directly or through the pointer. Code can therefore change banks, load the pointer and reach a register in another bank, whatever bank is currently selected. Read data is combinational from the presented offset. Writes take effect on the rising clock edge.

Top module: `bank_addr_unit`

## Requirements
- R1: After reset the status byte, the pointer and every array byte read as 00h, so bank 0 is selected and the high indirect bit is 0.
- R2: A direct access (offset not 00h) reaches physical location {status[6:5], offset}. Status bit 5 is the low bank bit and bit 6 is the high bank bit.
- R3: An access at offset 00h reaches physical location {status[7], pointer}. All eight pointer bits are the low address bits and status bit 7 is the ninth bit.
- R4: The status byte answers at offset 03h in each of the four banks, for both read and write.
- R5: The pointer register answers at offset 04h in each of the four banks, for both read and write.
- R6: An indirect access whose target has offset 00h in any bank reads 00h. A write to such a target changes no state.
- R7: A write to the status byte changes the bank and high indirect bits at the clock edge. The access in flight still uses the old values, and the next access uses the new ones.
- R8: With rd_en low, rd_data is 00h. With wr_en low, no state changes.
- R9: Locations with the same offset in different banks are separate storage. For example, physical 005h and 085h hold independent values.
- R10: Physical 18Ch is reached directly with bank 3 and offset 0Ch, and indirectly with pointer 8Ch and the high indirect bit set. Both paths reach the same byte.
- R11: An indirect target with offset 03h or 04h reaches the status byte or the pointer, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| file_addr | input | 7 | File offset from the instruction |
| rd_en | input | 1 | Read strobe; gates rd_data |
| wr_en | input | 1 | Write strobe; write lands at the next rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data from the addressed location |

## Verification
The bench first runs directed sequences. Each one writes through one address path and reads the byte back through the other. Because direct and indirect formation are compared on the same byte, a swapped or dropped high bit shows up as a miss. Other sequences write the same offset under different bank selections, which separates per-bank storage from mirrored storage. A status write followed at once by an access shows whether the new bank bits apply one access too early. A long pseudo-random phase then mixes status writes, pointer loads and indirect accesses, including pointers that land on the indirect window itself.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 7;
  localparam int BANK_W = 2;
  localparam int PHYS_W = OFS_W + BANK_W;
  localparam int HI_W   = PHYS_W - DATA_W;
  localparam int DEPTH  = 1 << PHYS_W;

  localparam logic [OFS_W-1:0] OFS_WINDOW = 7'h00;
  localparam logic [OFS_W-1:0] OFS_STATUS = 7'h03;
  localparam logic [OFS_W-1:0] OFS_PTR    = 7'h04;

  localparam int HI_BIT  = 7;
  localparam int BANK_LO = 5;

  typedef enum logic [1:0] {
    TGT_NULL   = 2'd0,
    TGT_STATUS = 2'd1,
    TGT_PTR    = 2'd2,
    TGT_ARRAY  = 2'd3
  } target_e;

  function automatic logic [PHYS_W-1:0] form_direct(
    input logic [BANK_W-1:0] bank,
    input logic [OFS_W-1:0]  ofs
  );
    return {bank, ofs};
  endfunction

  function automatic logic [PHYS_W-1:0] form_indirect(
    input logic [HI_W-1:0]   hi,
    input logic [DATA_W-1:0] ptr
  );
    return {hi, ptr};
  endfunction

  function automatic target_e classify(input logic [OFS_W-1:0] ofs);
    if (ofs == OFS_WINDOW)      return TGT_NULL;
    else if (ofs == OFS_STATUS) return TGT_STATUS;
    else if (ofs == OFS_PTR)    return TGT_PTR;
    else                        return TGT_ARRAY;
  endfunction
endpackage

// File: rtl/bank_addr_former.sv
module bank_addr_former
  import bank_addr_pkg::*;
(
  input  logic [OFS_W-1:0]  file_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [HI_W-1:0]   hi_sel,
  input  logic [DATA_W-1:0] ptr,
  output logic              via_ptr,
  output logic [PHYS_W-1:0] phys_addr
);
  always_comb begin
    via_ptr = (file_addr == OFS_WINDOW);
    if (via_ptr) phys_addr = form_indirect(hi_sel, ptr);
    else         phys_addr = form_direct(bank_sel, file_addr);
  end
endmodule

// File: rtl/bank_target_decode.sv
module bank_target_decode
  import bank_addr_pkg::*;
(
  input  logic [OFS_W-1:0] phys_ofs,
  output target_e          target,
  output logic             hit_null,
  output logic             hit_status,
  output logic             hit_ptr,
  output logic             hit_array
);
  always_comb begin
    target     = classify(phys_ofs);
    hit_null   = (target == TGT_NULL);
    hit_status = (target == TGT_STATUS);
    hit_ptr    = (target == TGT_PTR);
    hit_array  = (target == TGT_ARRAY);
  end
endmodule

// File: rtl/bank_file_array.sv
module bank_file_array
  import bank_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PHYS_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R9: a write lands at its own physical location
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bank_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        file_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] ptr_q;
  logic [PHYS_W-1:0] phys_addr;
  logic              via_ptr;
  target_e           target;
  logic              hit_null, hit_status, hit_ptr, hit_array;
  logic              arr_we;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] sel_data;
  logic [BANK_W-1:0] bank_sel;
  logic [HI_W-1:0]   hi_sel;

  assign bank_sel = status_q[BANK_LO +: BANK_W];
  assign hi_sel   = status_q[HI_BIT -: HI_W];

  bank_addr_former u_former (
    .file_addr (file_addr),
    .bank_sel  (bank_sel),
    .hi_sel    (hi_sel),
    .ptr       (ptr_q),
    .via_ptr   (via_ptr),
    .phys_addr (phys_addr)
  );

  bank_target_decode u_decode (
    .phys_ofs   (phys_addr[OFS_W-1:0]),
    .target     (target),
    .hit_null   (hit_null),
    .hit_status (hit_status),
    .hit_ptr    (hit_ptr),
    .hit_array  (hit_array)
  );

  assign arr_we = wr_en && hit_array;

  bank_file_array u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .addr  (phys_addr),
    .wdata (wr_data),
    .rdata (arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ptr_q    <= '0;
    end else if (wr_en) begin
      if (hit_status) status_q <= wr_data;
      if (hit_ptr)    ptr_q    <= wr_data;
    end
  end

  always_comb begin
    unique case (target)
      TGT_NULL:   sel_data = '0;
      TGT_STATUS: sel_data = status_q;
      TGT_PTR:    sel_data = ptr_q;
      default:    sel_data = arr_rdata;
    endcase
    rd_data = rd_en ? sel_data : '0;
  end

  // R2: direct accesses take the bank bits from the status byte
  a_r2_direct_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !via_ptr |-> (phys_addr[PHYS_W-1:OFS_W] == status_q[BANK_LO +: BANK_W]
                  && phys_addr[OFS_W-1:0] == file_addr));

  // R3: window accesses use the pointer plus the high bit
  a_r3_indirect_form: assert property (@(posedge clk) disable iff (!rst_n)
    via_ptr |-> phys_addr == {status_q[HI_BIT], ptr_q});

  // decode yields exactly one target
  a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_null, hit_status, hit_ptr, hit_array}) == 1);

  // R7: status write visible from the next cycle
  a_r7_status_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_status) |=> status_q == $past(wr_data));

  // R6: a write aimed at the window itself changes nothing
  a_r6_null_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_null) |=> ($stable(status_q) && $stable(ptr_q)));

  // R8: without a write strobe the held registers stay put
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(status_q) && $stable(ptr_q)));
endmodule

// File: tb/tb_bank_addr_unit.sv
module tb_bank_addr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] file_addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int applied = 0;
  int bad = 0;
  bit reported = 0;

  logic [7:0] m_mem [512];
  logic [7:0] m_stat;
  logic [7:0] m_ptr;

  bank_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  function automatic int where(input int ofs);
    if (ofs == 0) return (((m_stat >> 7) & 1) * 256) + m_ptr;
    return (((m_stat >> 5) & 3) * 128) + ofs;
  endfunction

  function automatic logic [7:0] m_read(input int ofs);
    int p = where(ofs);
    if ((p % 128) == 0) return 8'h00;
    if ((p % 128) == 3) return m_stat;
    if ((p % 128) == 4) return m_ptr;
    return m_mem[p];
  endfunction

  task automatic m_write(input int ofs, input logic [7:0] d);
    int p = where(ofs);
    if ((p % 128) == 3)      m_stat = d;
    else if ((p % 128) == 4) m_ptr = d;
    else if ((p % 128) != 0) m_mem[p] = d;
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    end
  endtask

  task automatic step(input int ofs, input bit rd, input bit wr,
                      input logic [7:0] d, input string req);
    logic [7:0] exp;
    @(negedge clk);
    file_addr = ofs[6:0];
    rd_en = rd;
    wr_en = wr;
    wr_data = d;
    #1;
    exp = rd ? m_read(ofs) : 8'h00;
    applied++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s ofs=%02h actual=%02h expected=%02h", req, ofs, rd_data, exp);
    end
    @(posedge clk);
    if (wr) m_write(ofs, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
    m_stat = 8'h00;
    m_ptr = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step(3, 1, 0, 0, "R1");
    step(4, 1, 0, 0, "R1");
    step(7'h20, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");

    step(5, 0, 1, 8'hAA, "R2");
    step(5, 1, 0, 0, "R2");
    step(5, 1, 0, 0, "R8");          // rd_en low check below
    step(5, 0, 0, 0, "R8");
    step(5, 0, 0, 8'h99, "R8");      // no strobe: no write
    step(5, 1, 0, 0, "R8");

    step(3, 1, 1, 8'h20, "R7");      // read returns old status
    step(5, 1, 0, 0, "R9");          // bank 1 -> 085h is empty
    step(5, 0, 1, 8'h55, "R9");
    step(5, 1, 0, 0, "R9");
    step(3, 1, 0, 0, "R4");
    step(4, 1, 1, 8'h05, "R5");
    step(0, 1, 0, 0, "R3");          // 005h = AA
    step(4, 1, 1, 8'h85, "R5");
    step(0, 1, 0, 0, "R3");          // 085h = 55

    step(3, 1, 1, 8'h60, "R4");      // bank 3
    step(3, 1, 0, 0, "R4");
    step(4, 1, 0, 0, "R5");
    step(7'h0C, 0, 1, 8'h3C, "R10");
    step(7'h0C, 1, 0, 0, "R10");
    step(3, 1, 1, 8'h80, "R7");      // bank 0, high bit set
    step(7'h0C, 1, 0, 0, "R7");      // now 00Ch
    step(4, 1, 1, 8'h8C, "R10");
    step(0, 1, 0, 0, "R10");         // 18Ch = 3C
    step(0, 1, 1, 8'hC3, "R10");
    step(3, 1, 1, 8'h60, "R10");
    step(7'h0C, 1, 0, 0, "R10");     // bank 3 sees C3

    step(3, 1, 1, 8'h80, "R6");
    step(4, 1, 1, 8'h80, "R6");      // target 180h
    step(0, 1, 1, 8'h77, "R6");
    step(3, 1, 0, 0, "R6");
    step(4, 1, 0, 0, "R6");
    step(3, 1, 1, 8'h00, "R6");
    step(4, 1, 1, 8'h00, "R6");      // target 000h
    step(0, 1, 1, 8'h66, "R6");
    step(4, 1, 0, 0, "R6");

    step(4, 1, 1, 8'h83, "R11");     // target 083h = status
    step(0, 1, 0, 0, "R11");
    step(4, 1, 1, 8'h84, "R11");     // target 084h = pointer
    step(0, 1, 1, 8'h12, "R11");
    step(4, 1, 0, 0, "R11");

    for (int n = 0; n < 3000; n++) begin
      int ofs;
      int pick = $urandom_range(0, 9);
      if (pick < 2)      ofs = 0;
      else if (pick < 3) ofs = 3;
      else if (pick < 5) ofs = 4;
      else               ofs = $urandom_range(0, 127);
      step(ofs, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           8'($urandom_range(0, 255)), "R2");
    end

    report();
    $finish;
  end
endmodule